// File: doc/BRIEF.md
# Cascadable Three-Tap FIR Filter Cell

This block is one slice of a transposed-form FIR filter. Each clock it takes one two's complement data sample from a data bus that all slices share. The registered sample is multiplied by three coefficient registers at the same time. The products are added into a pipelined partial sum that moves from the leftmost tap (C1) towards the rightmost tap (C3). For that reason the impulse response comes out with C3 first, then C2, then C1. A 16-bit chain input lets an upstream slice's output enter the left end of the pipeline, so slices wired output-to-input form a longer filter. The output of the last slice is the filter result.

A 3-bit bypass selector sets where zero stages sit. Bit 0 chooses between a registered chain input and an unregistered one. Bits 1 and 2 each enable an extra pipeline register between two neighbouring taps, and each enabled register delays the taps on its left by one more sample. The internal sum keeps six fraction bits below the output. A half-LSB bias is added in the last tap, the six bits are then dropped, and the result saturates to 16 bits. Coefficients are loaded from a shared bus under one write strobe per tap. If a new set is written C1, then C2, then C3 on consecutive clocks, no output ever mixes the old and new sets.

Top module: `tri_tap_fir`

The cell has no state machine. Its configuration is static: the bypass selector is held between resets, and each of its eight values is a fixed arrangement of the pipeline. The cell therefore has no states or transitions to list.

## Requirements
- R1: A synchronous reset clears the data, coefficient, chain and pipeline registers. `chain_out` reads 0 after any clock edge taken in reset, and stays 0 afterwards until a non-zero sample or chain value is applied.
- R2: A sample on `din` and a coefficient written at the same edge k reach the C3 term of `chain_out` just after edge k+1.
- R3: With `bypass_sel[2:1]` = 11, an impulse of value v taken at edge k gives round(C3·v) after edge k+1, round(C2·v) after k+2 and round(C1·v) after k+3. The output is 0 after that.
- R4: With `bypass_sel[2]` = 0, one zero-output cycle is inserted between the C3 and C2 terms of the impulse response.
- R5: With `bypass_sel[1]` = 0, one zero-output cycle is inserted between the C2 and C1 terms of the impulse response.
- R6: With all selector bits high, a value on `chain_in` at edge k appears unchanged on `chain_out` after edge k+2. A low `bypass_sel[0]` registers `chain_in` and adds one cycle. Each low bit among `bypass_sel[2:1]` adds one more cycle.
- R7: The output is floor((S + 32) / 64), where S is the full-precision sum at 2^-6 output-LSB resolution. For C3 = 1 and samples 31, 32, -32 and -33 the outputs are 0, 1, 0 and -1.
- R8: A result above 32767 reads 32767 and a result below -32768 reads -32768. The output never wraps.
- R9: `coef_wr` bit 0 writes C1, bit 1 writes C2 and bit 2 writes C3 from `coef_bus` at a rising edge. Taps whose bit is low keep their value. A coefficient written at edge k multiplies the sample taken at edge k.
- R10: With `bypass_sel[2:1]` = 11 and constant data, writing a new set C1, C2, C3 on three consecutive edges gives outputs that are each the old-set response or the new-set response, never a mix of the two.
- R11: Two slices with all selector bits high, the downstream `chain_in` driven by the upstream `chain_out`, form a six-tap filter whose response is downstream C3, C2, C1 followed by upstream C3, C2, C1. A low `bypass_sel[0]` on the downstream slice puts one zero between the two groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bypass_sel | input | 3 | Bit 0: chain input unregistered when high. Bit 1: no extra stage between C1 and C2 when high. Bit 2: no extra stage between C2 and C3 when high |
| din | input | 10 | Data sample, two's complement fraction |
| coef_bus | input | 10 | Shared coefficient value, two's complement fraction |
| coef_wr | input | 3 | Per-tap write strobes (bit 0 = C1, bit 2 = C3) |
| chain_in | input | 16 | Partial sum from the upstream slice |
| chain_out | output | 16 | Rounded, saturated partial sum or filter output |

## Verification
The assertions assume that `bypass_sel` is changed only while reset is held. The delay-stage and chain-register properties still tolerate a change, because they excuse the cycle in which the selector goes high. The no-wrap property assumes that the two guard bits absorb the worst case: three full-scale products plus a full-scale chain input. The stimulus drives all of these extremes, and it sets every selector value only inside a reset window. Data, coefficients and chain values change only at the falling edge, so each rising edge samples settled inputs.

// File: rtl/tri_tap_fir_pkg.sv
package tri_tap_fir_pkg;

    // Default geometry of one slice
    localparam int DFLT_DATA_W  = 10;
    localparam int DFLT_COEF_W  = 10;
    localparam int DFLT_OUT_W   = 16;
    localparam int DFLT_DROP_W  = 6;
    localparam int DFLT_GUARD_W = 2;
    localparam int DFLT_NTAPS   = 3;

    // Bit position of the half-LSB bias below the kept output bits
    function automatic int bias_pos(input int drop_w);
        return (drop_w > 0) ? drop_w - 1 : 0;
    endfunction

endpackage

// File: rtl/tri_tap_fir_tap.sv
module tri_tap_fir_tap
    import tri_tap_fir_pkg::*;
#(
    parameter int DATA_W  = DFLT_DATA_W,
    parameter int COEF_W  = DFLT_COEF_W,
    parameter int SUM_W   = 24,
    parameter int DROP_W  = DFLT_DROP_W,
    parameter bit ADD_RND = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic        [COEF_W-1:0] coef_bus,
    input  logic signed [DATA_W-1:0] dq,
    input  logic signed [SUM_W-1:0]  acc_in,
    output logic signed [SUM_W-1:0]  acc_q
);

    localparam int PROD_W = DATA_W + COEF_W;
    localparam logic [SUM_W-1:0] ONE  = {{(SUM_W-1){1'b0}}, 1'b1};
    localparam logic [SUM_W-1:0] BIAS = ADD_RND ? (ONE << bias_pos(DROP_W)) : '0;

    logic signed [COEF_W-1:0] coef_q;
    logic signed [PROD_W-1:0] prod;
    logic signed [SUM_W-1:0]  acc_d;

    // Coefficient register: written only under its own strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            coef_q <= '0;
        end else if (wr) begin
            coef_q <= coef_bus;
        end
    end

    always_comb begin
        prod  = PROD_W'(coef_q) * PROD_W'(dq);
        acc_d = acc_in + SUM_W'(prod) + $signed(BIAS);
    end

    // Partial-sum register of this tap
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // R9
    coef_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (coef_q == $past(coef_bus)));

    // R9
    coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(coef_q));

endmodule

// File: rtl/tri_tap_fir_gap.sv
module tri_tap_fir_gap #(
    parameter int W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bypass,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);

    logic signed [W-1:0] held;

    // Extra stage always clocks; the selector only picks the tap point
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else begin
            held <= din;
        end
    end

    always_comb begin
        dout = bypass ? din : held;
    end

    // R4 R5
    gap_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !bypass |=> (bypass || (dout == $past(din))));

endmodule

// File: rtl/tri_tap_fir_rndsat.sv
module tri_tap_fir_rndsat #(
    parameter int SUM_W  = 24,
    parameter int OUT_W  = 16,
    parameter int DROP_W = 6
) (
    input  logic signed [SUM_W-1:0] acc,
    output logic        [OUT_W-1:0] res
);

    localparam int ACC_W  = OUT_W + DROP_W;
    localparam int HEAD_W = SUM_W - ACC_W + 1;
    localparam logic [OUT_W-1:0] MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};

    logic [HEAD_W-1:0] head;
    logic              ovf;
    logic              drop_unused;

    always_comb begin
        head        = acc[SUM_W-1:ACC_W-1];
        ovf         = !((&head) || (~|head));
        drop_unused = ^acc[DROP_W-1:0];
        if (ovf) begin
            res = acc[SUM_W-1] ? MIN_V : MAX_V;
        end else begin
            res = acc[ACC_W-1:DROP_W];
        end
    end

endmodule

// File: rtl/tri_tap_fir.sv
module tri_tap_fir
    import tri_tap_fir_pkg::*;
#(
    parameter int DATA_W  = DFLT_DATA_W,
    parameter int COEF_W  = DFLT_COEF_W,
    parameter int OUT_W   = DFLT_OUT_W,
    parameter int DROP_W  = DFLT_DROP_W,
    parameter int GUARD_W = DFLT_GUARD_W,
    parameter int NTAPS   = DFLT_NTAPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NTAPS-1:0]  bypass_sel,
    input  logic [DATA_W-1:0] din,
    input  logic [COEF_W-1:0] coef_bus,
    input  logic [NTAPS-1:0]  coef_wr,
    input  logic [OUT_W-1:0]  chain_in,
    output logic [OUT_W-1:0]  chain_out
);

    localparam int ACC_W = OUT_W + DROP_W;
    localparam int SUM_W = ACC_W + GUARD_W;

    logic signed [DATA_W-1:0] din_q;
    logic        [OUT_W-1:0]  chain_q;
    logic        [OUT_W-1:0]  head;
    logic signed [SUM_W-1:0]  link  [NTAPS];
    logic signed [SUM_W-1:0]  stage [NTAPS];

    // Shared sample register and optional chain-input register
    always_ff @(posedge clk) begin
        if (rst) begin
            din_q   <= '0;
            chain_q <= '0;
        end else begin
            din_q   <= din;
            chain_q <= chain_in;
        end
    end

    always_comb begin
        head    = bypass_sel[0] ? chain_in : chain_q;
        link[0] = {{GUARD_W{head[OUT_W-1]}}, head, {DROP_W{1'b0}}};
    end

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        tri_tap_fir_tap #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .SUM_W  (SUM_W),
            .DROP_W (DROP_W),
            .ADD_RND(k == NTAPS - 1)
        ) u_tap (
            .clk     (clk),
            .rst     (rst),
            .wr      (coef_wr[k]),
            .coef_bus(coef_bus),
            .dq      (din_q),
            .acc_in  (link[k]),
            .acc_q   (stage[k])
        );

        if (k < NTAPS - 1) begin : g_gap
            tri_tap_fir_gap #(
                .W(SUM_W)
            ) u_gap (
                .clk   (clk),
                .rst   (rst),
                .bypass(bypass_sel[k+1]),
                .din   (stage[k]),
                .dout  (link[k+1])
            );
        end
    end

    tri_tap_fir_rndsat #(
        .SUM_W (SUM_W),
        .OUT_W (OUT_W),
        .DROP_W(DROP_W)
    ) u_rndsat (
        .acc(stage[NTAPS-1]),
        .res(chain_out)
    );

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        stage[NTAPS-1][SUM_W-1] == chain_out[OUT_W-1]);

    // R6
    chain_reg_chk: assert property (@(posedge clk) disable iff (rst)
        !bypass_sel[0] |=> (bypass_sel[0] ||
            (link[0][ACC_W-1:DROP_W] == $past(chain_in))));

endmodule

// File: tb/tri_tap_fir_bench.sv
module tri_tap_fir_bench;

    localparam int DW = 10;
    localparam int CW = 10;
    localparam int OW = 16;
    localparam int DEPTH = 1024;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic [DW-1:0] din = '0;
    logic [CW-1:0] coef_bus = '0;
    logic [2:0] wr_up = '0, wr_mn = '0, sel_up = 3'b111, sel_mn = 3'b111;
    logic signed [OW-1:0] tb_chain = '0;
    logic signed [OW-1:0] up_out, mn_out, mn_in;
    logic casc = 1'b0;

    assign mn_in = casc ? up_out : tb_chain;

    tri_tap_fir u_tri_tap_fir_up (
        .clk(clk), .rst(rst), .bypass_sel(sel_up), .din(din), .coef_bus(coef_bus),
        .coef_wr(wr_up), .chain_in(tb_chain), .chain_out(up_out));

    tri_tap_fir u_tri_tap_fir (
        .clk(clk), .rst(rst), .bypass_sel(sel_mn), .din(din), .coef_bus(coef_bus),
        .coef_wr(wr_mn), .chain_in(mn_in), .chain_out(mn_out));

    int n_chk = 0, n_fail = 0;
    int edge_n = 0, lr = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    int xh [DEPTH];
    int ch [2][3][DEPTH];
    int sh [2][DEPTH];
    int yx [2][DEPTH];
    int cur_c [2][3];

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural convolution: sum over the sampled history with delays set by the selector
    function automatic int model(input int i, input int e, input logic [2:0] sel);
        int g2, g1, g0, j3, j2, j1, js;
        longint s;
        g2 = sel[2] ? 0 : 1;
        g1 = sel[1] ? 0 : 1;
        g0 = sel[0] ? 0 : 1;
        j3 = e - 1;
        j2 = e - 2 - g2;
        j1 = e - 3 - g2 - g1;
        js = e - 2 - g2 - g1 - g0;
        s = 32;
        if (j3 > lr) s += longint'(ch[i][2][j3]) * xh[j3];
        if (j2 > lr) s += longint'(ch[i][1][j2]) * xh[j2];
        if (j1 > lr) s += longint'(ch[i][0][j1]) * xh[j1];
        if (js > lr) s += longint'(sh[i][js]) * 64;
        s = s >>> 6;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return int'(s);
    endfunction

    always @(posedge clk) begin
        edge_n++;
        if (rst) begin
            lr = edge_n;
            xh[edge_n] = 0;
            for (int i = 0; i < 2; i++) begin
                for (int t = 0; t < 3; t++) begin
                    cur_c[i][t] = 0;
                    ch[i][t][edge_n] = 0;
                end
                sh[i][edge_n] = 0;
                yx[i][edge_n] = 0;
            end
        end else begin
            xh[edge_n] = int'($signed(din));
            for (int t = 0; t < 3; t++) begin
                if (wr_up[t]) cur_c[0][t] = int'($signed(coef_bus));
                if (wr_mn[t]) cur_c[1][t] = int'($signed(coef_bus));
                ch[0][t][edge_n] = cur_c[0][t];
                ch[1][t][edge_n] = cur_c[1][t];
            end
            sh[0][edge_n] = int'(tb_chain);
            sh[1][edge_n] = casc ? yx[0][edge_n-1] : int'(tb_chain);
            yx[0][edge_n] = model(0, edge_n, sel_up);
            yx[1][edge_n] = model(1, edge_n, sel_mn);
        end
    end

    // Reference comparison on every clock, away from the rising edge
    always @(negedge clk) begin
        if (edge_n > 0 && !done) begin
            check({cur_req, " model upstream"}, int'(up_out), yx[0][edge_n]);
            check({cur_req, " model main"}, int'(mn_out), yx[1][edge_n]);
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] su, input logic [2:0] sm, input logic cc);
        rst = 1'b1;
        sel_up = su;
        sel_mn = sm;
        casc = cc;
        din = '0;
        tb_chain = '0;
        wr_up = '0;
        wr_mn = '0;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic load(input int inst, input int tap, input int val);
        coef_bus = CW'(val);
        if (inst == 0) wr_up = 3'(1 << tap);
        else wr_mn = 3'(1 << tap);
        step();
        wr_up = '0;
        wr_mn = '0;
    endtask

    task automatic expect_next(input string req, input int exp);
        step();
        check(req, int'(mn_out), exp);
    endtask

    task automatic impulse();
        din = DW'(64);
        step();
        din = '0;
    endtask

    initial begin
        // R1: junk inputs during reset
        din = DW'(123);
        coef_bus = CW'(99);
        wr_mn = 3'b111;
        wr_up = 3'b111;
        tb_chain = 16'sd500;
        step();
        step();
        check("R1 reset output", int'(mn_out), 0);
        wr_mn = '0;
        wr_up = '0;
        din = '0;
        tb_chain = '0;
        rst = 1'b0;
        impulse();
        for (int k = 0; k < 4; k++) expect_next("R1 coefficients cleared", 0);

        // R2 R3: basic impulse order
        cur_req = "R3";
        do_reset(3'b111, 3'b111, 1'b0);
        load(1, 0, 3);
        load(1, 1, -7);
        load(1, 2, 11);
        impulse();
        expect_next("R2 C3 latency", 11);
        expect_next("R3 C2 term", -7);
        expect_next("R3 C1 term", 3);
        expect_next("R3 tail", 0);

        // R4: gap between C3 and C2
        cur_req = "R4";
        do_reset(3'b111, 3'b011, 1'b0);
        load(1, 0, 3);
        load(1, 1, -7);
        load(1, 2, 11);
        impulse();
        expect_next("R4 C3", 11);
        expect_next("R4 zero stage", 0);
        expect_next("R4 C2", -7);
        expect_next("R4 C1", 3);

        // R5: gap between C2 and C1
        cur_req = "R5";
        do_reset(3'b111, 3'b101, 1'b0);
        load(1, 0, 3);
        load(1, 1, -7);
        load(1, 2, 11);
        impulse();
        expect_next("R5 C3", 11);
        expect_next("R5 C2", -7);
        expect_next("R5 zero stage", 0);
        expect_next("R5 C1", 3);

        // R6: chain input latency
        cur_req = "R6";
        do_reset(3'b111, 3'b111, 1'b0);
        tb_chain = 16'sd1000;
        step();
        tb_chain = '0;
        check("R6 chain not yet", int'(mn_out), 0);
        expect_next("R6 chain not yet", 0);
        expect_next("R6 chain passthrough", 1000);
        do_reset(3'b110, 3'b110, 1'b0);
        tb_chain = -16'sd5;
        step();
        tb_chain = '0;
        check("R6 registered chain", int'(mn_out), 0);
        expect_next("R6 registered chain", 0);
        expect_next("R6 registered chain", 0);
        expect_next("R6 registered chain value", -5);

        // R7: rounding of dropped bits (only C3 written: R9 isolation)
        cur_req = "R7";
        do_reset(3'b111, 3'b111, 1'b0);
        load(1, 2, 1);
        din = DW'(31);
        step();
        din = DW'(32);
        expect_next("R7 31 rounds to", 0);
        din = DW'(-32);
        expect_next("R7 32 rounds to", 1);
        din = DW'(-33);
        expect_next("R7 -32 rounds to", 0);
        din = '0;
        expect_next("R7 -33 rounds to", -1);

        // R8: saturation both ways
        cur_req = "R8";
        do_reset(3'b111, 3'b111, 1'b0);
        load(1, 0, -512);
        load(1, 1, -512);
        load(1, 2, -512);
        din = DW'(-512);
        tb_chain = 16'sd32767;
        for (int k = 0; k < 4; k++) step();
        check("R8 positive clip", int'(mn_out), 32767);
        din = DW'(511);
        tb_chain = -16'sd32768;
        for (int k = 0; k < 4; k++) step();
        check("R8 negative clip", int'(mn_out), -32768);
        din = '0;
        tb_chain = '0;

        // R9: single-tap write and same-edge use
        cur_req = "R9";
        do_reset(3'b111, 3'b111, 1'b0);
        load(1, 0, 3);
        load(1, 1, -7);
        load(1, 2, 11);
        load(1, 1, 20);
        impulse();
        expect_next("R9 C3 kept", 11);
        expect_next("R9 C2 rewritten", 20);
        expect_next("R9 C1 kept", 3);
        coef_bus = CW'(7);
        wr_mn = 3'b100;
        din = DW'(64);
        step();
        wr_mn = '0;
        din = '0;
        expect_next("R9 same-edge coefficient", 7);
        expect_next("R9 C2 after", 20);
        expect_next("R9 C1 after", 3);

        // R10: left-to-right update never mixes sets
        cur_req = "R10";
        do_reset(3'b111, 3'b111, 1'b0);
        load(1, 0, 1);
        load(1, 1, 2);
        load(1, 2, 3);
        din = DW'(64);
        for (int k = 0; k < 4; k++) step();
        check("R10 old set", int'(mn_out), 6);
        for (int k = 0; k < 3; k++) begin
            coef_bus = CW'(10 * (k + 1));
            wr_mn = 3'(1 << k);
            step();
            check("R10 no mixed set", (mn_out == 6 || mn_out == 60) ? 1 : 0, 1);
        end
        wr_mn = '0;
        for (int k = 0; k < 4; k++) begin
            step();
            check("R10 no mixed set", (mn_out == 6 || mn_out == 60) ? 1 : 0, 1);
        end
        check("R10 new set", int'(mn_out), 60);
        din = '0;

        // R11: two-slice cascade
        cur_req = "R11";
        do_reset(3'b111, 3'b111, 1'b1);
        load(0, 0, 1);
        load(0, 1, 2);
        load(0, 2, 3);
        load(1, 0, 4);
        load(1, 1, 5);
        load(1, 2, 6);
        impulse();
        expect_next("R11 tap1", 6);
        expect_next("R11 tap2", 5);
        expect_next("R11 tap3", 4);
        expect_next("R11 tap4", 3);
        expect_next("R11 tap5", 2);
        expect_next("R11 tap6", 1);
        expect_next("R11 tail", 0);
        do_reset(3'b111, 3'b110, 1'b1);
        load(0, 0, 1);
        load(0, 1, 2);
        load(0, 2, 3);
        load(1, 0, 4);
        load(1, 1, 5);
        load(1, 2, 6);
        impulse();
        expect_next("R11 gap tap1", 6);
        expect_next("R11 gap tap2", 5);
        expect_next("R11 gap tap3", 4);
        expect_next("R11 gap zero", 0);
        expect_next("R11 gap tap4", 3);
        expect_next("R11 gap tap5", 2);
        expect_next("R11 gap tap6", 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hang expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule